// File: doc/BRIEF.md
# Hint-Guided Set-Associative Tag Array

This block holds the tag side of a set-associative cache and decides which way a miss replaces. Each line keeps a valid bit, a tag, a recency age and one extra bit that marks the line as a preferred candidate for replacement. Each request carries a no-reuse flag, set by compiler-generated instructions when the data is not expected to be used again soon, and a prefetch flag. The tag compare and the hit result work as in a plain LRU cache. Only the miss path reads the extra bit.

On a miss the block fills the lowest-numbered invalid way if the set has one. Otherwise it evicts a line whose replacement bit is set, taking the least recently used of those lines. If no line in the set has the bit set, it evicts the least recently used line. The new tag is installed in the same cycle. The replaced line's tag is reported so that a writeback can be started. A flagged line is not dropped early: it stays resident and keeps hitting until a later miss in its set selects it.

Top module: `hvc_tag_array`

## Requirements
- R1: A synchronous reset clears every valid bit, replacement bit and age. After reset the first request to each set misses, the block reports way 0, and it reports no evicted line.
- R2: A request in cycle N gives exactly one of `rsp_hit` or `rsp_miss` high in cycle N+1. A hit means the set holds a valid line with a matching tag. With no request, both outputs are low in the next cycle.
- R3: On a miss in a set with an invalid way, the lowest-numbered invalid way is filled, and no evicted line is reported.
- R4: On a miss in a full set where at least one line has its replacement bit set, the victim is one of the flagged lines.
- R5: When several lines in a full set are flagged, the victim is the flagged line used least recently.
- R6: When no line in a full set is flagged, the victim is the least recently used line. Recency counts both fills and hits.
- R7: A fill stores the replacement bit as `req_no_reuse AND NOT req_prefetch`. A prefetch therefore never sets it.
- R8: On a hit, the line's replacement bit is overwritten with the same expression taken from the current request, and the line becomes most recently used.
- R9: A flagged line stays valid and keeps hitting until a miss in its set selects it as victim.
- R10: On a miss, `rsp_way` is the filled way. `rsp_evict_valid` is high only if that way held a valid line, and `rsp_evict_tag` then gives that line's tag. On a hit, `rsp_way` is the hitting way and `rsp_evict_valid` is low.
- R11: The set index is the low `IDX_W` bits of `req_addr`, and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | TAG_W+IDX_W | Tag (upper bits) and set index (low bits) |
| req_no_reuse | input | 1 | Data not expected to be reused soon |
| req_prefetch | input | 1 | Request is a prefetch fill |
| rsp_hit | output | 1 | Previous request hit |
| rsp_miss | output | 1 | Previous request missed |
| rsp_way | output | WAY_W | Way that hit or was filled |
| rsp_evict_valid | output | 1 | A valid line was replaced |
| rsp_evict_tag | output | TAG_W | Tag of the replaced line |

## Verification
The bench builds the block with 4 sets, 4 ways and a 3-bit tag. With four ways, a full set can hold zero, one or several flagged lines at once, so every branch of the victim choice occurs, including the choice between several flagged lines. The narrow tag and small set count make conflicts and hits frequent in a long random sweep of load, no-reuse and prefetch requests. Each response in the sweep is compared with a model that tracks last-use time stamps per line, which is independent of the age counters used in the block.

// File: rtl/hvc_pkg.sv
package hvc_pkg;
    // Index width for a count of n items, never below one bit
    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/hvc_way_match.sv
module hvc_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int WAY_W = hvc_pkg::bits_for(WAYS)
) (
    input  logic [WAYS-1:0]             line_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  line_tag,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        any_hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = line_vld[g] && (line_tag[g] == look_tag);
    end

    always_comb begin
        any_hit = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/hvc_victim_pick.sv
module hvc_victim_pick #(
    parameter int WAYS  = 2,
    localparam int WAY_W = hvc_pkg::bits_for(WAYS),
    localparam int AGE_W = hvc_pkg::bits_for(WAYS)
) (
    input  logic [WAYS-1:0]             line_vld,
    input  logic [WAYS-1:0]             line_hint,
    input  logic [WAYS-1:0][AGE_W-1:0]  line_age,
    output logic [WAY_W-1:0]            pick_way
);
    logic [WAYS-1:0]  pool;
    logic [AGE_W-1:0] best_age;
    logic             found;

    always_comb begin
        pick_way = '0;
        best_age = '0;
        found    = 1'b0;
        pool     = (|line_hint) ? line_hint : '1;
        if (!(&line_vld)) begin
            // lowest invalid way wins
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!line_vld[w]) pick_way = WAY_W'(w);
            end
        end else begin
            // oldest line within the flagged pool (or all lines)
            for (int w = 0; w < WAYS; w++) begin
                if (pool[w] && (!found || line_age[w] > best_age)) begin
                    pick_way = WAY_W'(w);
                    best_age = line_age[w];
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hvc_age_update.sv
module hvc_age_update #(
    parameter int WAYS  = 2,
    localparam int WAY_W = hvc_pkg::bits_for(WAYS),
    localparam int AGE_W = hvc_pkg::bits_for(WAYS)
) (
    input  logic [WAYS-1:0][AGE_W-1:0]  age_in,
    input  logic [WAY_W-1:0]            touch_way,
    output logic [WAYS-1:0][AGE_W-1:0]  age_out
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    logic [AGE_W-1:0] ref_age;

    always_comb begin
        ref_age = age_in[touch_way];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way) begin
                age_out[w] = '0;
            end else if (age_in[w] <= ref_age && age_in[w] != AGE_MAX) begin
                age_out[w] = age_in[w] + 1'b1;
            end else begin
                age_out[w] = age_in[w];
            end
        end
    end
endmodule

// File: rtl/hvc_tag_array.sv
module hvc_tag_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int IDX_W  = hvc_pkg::bits_for(SETS),
    localparam int WAY_W  = hvc_pkg::bits_for(WAYS),
    localparam int AGE_W  = hvc_pkg::bits_for(WAYS),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_no_reuse,
    input  logic              req_prefetch,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_evict_valid,
    output logic [TAG_W-1:0]  rsp_evict_tag
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0]             hnt;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age;
        logic                                  hit;
        logic                                  miss;
        logic [WAY_W-1:0]                      way;
        logic                                  ev_vld;
        logic [TAG_W-1:0]                      ev_tag;
    } state_t;

    state_t st_q, st_d;

    logic [IDX_W-1:0]             idx;
    logic [TAG_W-1:0]             lk_tag;
    logic [WAYS-1:0]              lk_valid;
    logic [WAYS-1:0]              lk_hint;
    logic [WAYS-1:0][TAG_W-1:0]   set_tags;
    logic [WAYS-1:0][AGE_W-1:0]   set_ages;
    logic [WAYS-1:0][AGE_W-1:0]   new_ages;
    logic                         lk_hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             pick_way;
    logic [WAY_W-1:0]             use_way;
    logic                         keep_hint;

    assign idx       = req_addr[IDX_W-1:0];
    assign lk_tag    = req_addr[ADDR_W-1:IDX_W];
    assign lk_valid  = st_q.vld[idx];
    assign lk_hint   = st_q.hnt[idx];
    assign set_tags  = st_q.tag[idx];
    assign set_ages  = st_q.age[idx];
    assign use_way   = lk_hit ? hit_way : pick_way;
    assign keep_hint = req_no_reuse & ~req_prefetch;

    hvc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
        .line_vld (lk_valid),
        .line_tag (set_tags),
        .look_tag (lk_tag),
        .any_hit  (lk_hit),
        .hit_way  (hit_way)
    );

    hvc_victim_pick #(.WAYS(WAYS)) pick_i (
        .line_vld  (lk_valid),
        .line_hint (lk_hint),
        .line_age  (set_ages),
        .pick_way  (pick_way)
    );

    hvc_age_update #(.WAYS(WAYS)) age_i (
        .age_in    (set_ages),
        .touch_way (use_way),
        .age_out   (new_ages)
    );

    always_comb begin
        st_d        = st_q;
        st_d.hit    = 1'b0;
        st_d.miss   = 1'b0;
        st_d.way    = '0;
        st_d.ev_vld = 1'b0;
        st_d.ev_tag = '0;
        if (req_valid) begin
            st_d.hit  = lk_hit;
            st_d.miss = !lk_hit;
            st_d.way  = use_way;
            if (!lk_hit) begin
                st_d.ev_vld = lk_valid[pick_way];
                st_d.ev_tag = lk_valid[pick_way] ? set_tags[pick_way] : '0;
            end
            st_d.vld[idx][use_way] = 1'b1;
            st_d.tag[idx][use_way] = lk_tag;
            st_d.hnt[idx][use_way] = keep_hint;
            st_d.age[idx]          = new_ages;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_hit         = st_q.hit;
    assign rsp_miss        = st_q.miss;
    assign rsp_way         = st_q.way;
    assign rsp_evict_valid = st_q.ev_vld;
    assign rsp_evict_tag   = st_q.ev_tag;
endmodule

// File: rtl/hvc_tag_array_chk.sv
module hvc_tag_array_chk #(
    parameter int WAYS  = 2,
    localparam int WAY_W = hvc_pkg::bits_for(WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             lk_hit,
    input logic [WAYS-1:0]  lk_valid,
    input logic [WAYS-1:0]  lk_hint,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [WAY_W-1:0] rsp_way,
    input logic             rsp_evict_valid
);
    logic [WAYS-1:0] vld_prev;
    logic [WAYS-1:0] hint_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_prev  <= '0;
            hint_prev <= '0;
        end else begin
            vld_prev  <= lk_valid;
            hint_prev <= lk_hint & lk_valid;
        end
    end

    // R2
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_miss));

    // R2
    answer_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_hit || rsp_miss));

    // R2
    hit_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk_hit) |=> rsp_hit);

    // R3
    free_first_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss && !(&vld_prev)) |-> (!rsp_evict_valid && !vld_prev[rsp_way]));

    // R4
    hint_pref_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss && (&vld_prev) && (|hint_prev)) |-> hint_prev[rsp_way]);

    // R10
    hit_no_evict_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> !rsp_evict_valid);

    // R10
    full_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss && (&vld_prev)) |-> rsp_evict_valid);
endmodule

bind hvc_tag_array hvc_tag_array_chk #(.WAYS(WAYS)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .lk_hit          (lk_hit),
    .lk_valid        (lk_valid),
    .lk_hint         (lk_hint),
    .rsp_hit         (rsp_hit),
    .rsp_miss        (rsp_miss),
    .rsp_way         (rsp_way),
    .rsp_evict_valid (rsp_evict_valid)
);

// File: tb/hvc_tag_array_tb_top.sv
module hvc_tag_array_tb_top;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int TAG_W = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [4:0] req_addr = '0;
    logic       req_no_reuse = 1'b0;
    logic       req_prefetch = 1'b0;
    logic       rsp_hit, rsp_miss, rsp_evict_valid;
    logic [1:0] rsp_way;
    logic [2:0] rsp_evict_tag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model: valid, flag, tag, last-use stamp
    bit m_vld [SETS][WAYS];
    bit m_hnt [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_ts  [SETS][WAYS];
    int now = 0;

    always #2.5 clk = ~clk;

    hvc_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_no_reuse(req_no_reuse), .req_prefetch(req_prefetch),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_way(rsp_way),
        .rsp_evict_valid(rsp_evict_valid), .rsp_evict_tag(rsp_evict_tag)
    );

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0; m_hnt[s][w] = 0; m_tag[s][w] = 0; m_ts[s][w] = 0;
            end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // Called at a negedge; leaves the bench at the next negedge.
    task automatic access(input int set, input int tg, input bit nr, input bit pf,
                          input string lbl);
        bit e_hit, e_ev;
        int e_way, e_evtag, nflag, best;
        string why;
        e_hit = 0; e_ev = 0; e_way = 0; e_evtag = 0; nflag = 0; best = -1;
        why = "R6";
        req_valid = 1'b1; req_addr = 5'((tg << 2) | set);   // R11 split
        req_no_reuse = nr; req_prefetch = pf;
        for (int w = 0; w < WAYS; w++)
            if (m_vld[set][w] && m_tag[set][w] == tg) begin e_hit = 1; e_way = w; end
        if (e_hit) why = "R8";
        else begin
            e_way = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[set][w]) e_way = w;
            if (e_way >= 0) why = "R3";
            else begin
                for (int w = 0; w < WAYS; w++) if (m_hnt[set][w]) nflag++;
                for (int w = 0; w < WAYS; w++)
                    if ((nflag == 0 || m_hnt[set][w]) && (best < 0 || m_ts[set][w] < best)) begin
                        best = m_ts[set][w]; e_way = w;
                    end
                why = (nflag == 0) ? "R6" : (nflag == 1 ? "R4" : "R5");
                e_ev = 1; e_evtag = m_tag[set][e_way];
            end
        end
        now++;
        m_vld[set][e_way] = 1; m_tag[set][e_way] = tg;
        m_hnt[set][e_way] = nr && !pf; m_ts[set][e_way] = now;
        if (lbl != "") why = lbl;
        @(negedge clk);
        checks++;
        if (rsp_hit !== e_hit || rsp_miss !== !e_hit || rsp_way !== 2'(e_way) ||
            rsp_evict_valid !== e_ev || (e_ev && rsp_evict_tag !== 3'(e_evtag))) begin
            errors++;
            $display("FAIL %s set=%0d tag=%0d: got hit=%0b miss=%0b way=%0d ev=%0b evtag=%0d, exp hit=%0b miss=%0b way=%0d ev=%0b evtag=%0d",
                     why, set, tg, rsp_hit, rsp_miss, rsp_way, rsp_evict_valid, rsp_evict_tag,
                     e_hit, !e_hit, e_way, e_ev, e_evtag);
        end
    endtask

    task automatic idle(input string lbl);
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            errors++;
            $display("FAIL %s idle: got hit=%0b miss=%0b, exp 0 0", lbl, rsp_hit, rsp_miss);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state and first access per set
        idle("R1");
        for (int s = 0; s < SETS; s++) access(s, 5, 0, 0, "R1");
        idle("R2");
        // R11: same tag, different sets are independent
        for (int s = 0; s < SETS; s++) access(s, 5, 0, 0, "R11");
        // R3: fill remaining ways of set 0 in order
        for (int t = 1; t < 4; t++) access(0, t, 0, 0, "R3");
        // R6: no flags, LRU is tag 5 in way 0
        access(0, 6, 0, 0, "R6");
        // R7: prefetch with no-reuse does not flag; set 1 full with prefetches
        for (int t = 0; t < 3; t++) access(1, t, 1, 1, "R7");
        access(1, 7, 0, 0, "R7");
        // R8 / R4: hit way 2 with flag, it becomes victim though most recent
        access(1, 1, 1, 0, "R8");
        access(1, 4, 0, 0, "R4");
        // R8: hit with flag cleared removes preference
        access(2, 1, 1, 0, "R3");
        access(2, 2, 1, 0, "R3");
        access(2, 3, 0, 0, "R3");
        access(2, 1, 0, 0, "R8");
        // R5: remaining flag on tag 2, flag tag 3 too; tag 2 older
        access(2, 3, 1, 0, "R8");
        access(2, 6, 0, 0, "R5");
        access(2, 7, 0, 0, "R10");
        // R9: flagged line keeps hitting
        access(3, 2, 1, 0, "R3");
        for (int i = 0; i < 3; i++) access(3, 2, 1, 0, "R9");
        idle("R2");
        // R10/R4..R6: random sweep against model
        for (int i = 0; i < 6000; i++) begin
            access(int'($urandom % SETS), int'($urandom % 8),
                   bit'($urandom % 2), bit'(($urandom % 4) == 0), "");
            if (($urandom % 8) == 0) idle("R2");
        end
        // R1: reset clears everything again
        do_reset();
        for (int s = 0; s < SETS; s++) access(s, 7, 0, 0, "R1");
        idle("R2");
        finish_run();
    end
endmodule